// File: doc/BRIEF.md
# Background Memory Signature Scanner

This block checks a read-only memory in the background while a processor runs from the same internal bus. In every cycle in which the processor leaves the bus idle, the scanner reads one word of a configured address window, starting at the lowest address and going upward. Each returned word is folded into a 16-bit multiple-input signature register. When the highest address of the window has been folded in, the resulting signature is compared with a reference value held in configuration, and a new pass starts at once.

A busy bus must not stall the check indefinitely. A down-counter is reloaded with a programmable window after every fetch. When it reaches zero, the scanner raises a bus request to an arbiter. When the grant comes back, the scanner takes that cycle even though the processor wanted it. The time for a pass therefore has an upper bound. A correct memory produces no interrupt. A wrong signature pulses an interrupt and sets a sticky error flag. A counter of finished passes is available for monitoring.

Configuration uses a small write port with four registers, chosen by a 2-bit select: start address (0), end address (1), reference signature (2) and control (3). The control word holds enable in bit 0, error-clear in bit 1 and the steal window in bits starting at bit 2.

Top module: `mem_sig_scanner`

## Requirements
- R1: A memory read (`mem_rd_en` high) is issued only in a cycle where `cpu_busy` is low or `scan_gnt` is high. While the bus stays busy and no grant is given, no read is issued and no pass completes.
- R2: Within a pass, reads cover every address from the start address to the end address (start ≤ end) in ascending order, one read per address. After the end address, the next read is the start address again.
- R3: The signature is seeded with 16'hFFFF at the start of each pass. For each word d, s' = ({s[14:0],0} XOR (s[15] ? 16'h1021 : 0)) XOR d. The value after the last word appears on `sig_out` when the pass finishes.
- R4: If the final signature differs from the reference, `irq` is high for exactly one cycle and `err_flag` is set. A match produces no `irq` pulse.
- R5: After each read, the steal counter is reloaded with the window W (control bits from bit 2 up, default 8). After W cycles with no read, `scan_req` rises, and a granted request issues a read in that cycle. With the bus always busy and the grant immediate, consecutive reads within a pass are exactly W+1 cycles apart.
- R6: `pass_count` increments by one for each finished pass, and the next pass begins without software action.
- R7: Writes to the start, end and reference registers are ignored while the scanner is enabled.
- R8: After reset, `irq`, `err_flag`, `scan_req`, `mem_rd_en`, `pass_count` and `sig_out` are all zero, and the scanner is disabled.
- R9: Clearing enable abandons the pass in progress. Setting enable again starts a fresh pass at the start address with a fresh seed.
- R10: Writing the control register with bit 1 set clears `err_flag`. A mismatch in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 start, 1 end, 2 reference, 3 control |
| cfg_wdata | input | CFG_W | Configuration write data |
| cpu_busy | input | 1 | Processor uses the bus this cycle |
| scan_req | output | 1 | Cycle-steal request to the arbiter |
| scan_gnt | input | 1 | Arbiter grants this cycle to the scanner |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdata | input | DATA_W | Read data, valid one cycle after the strobe |
| irq | output | 1 | One-cycle pulse on signature mismatch |
| err_flag | output | 1 | Sticky mismatch flag |
| pass_count | output | CNT_W | Finished passes |
| sig_out | output | DATA_W | Signature of the last finished pass |

## Verification
The assertions assume that the memory returns data exactly one cycle after a read strobe. They also assume that the arbiter grant comes only while a request is pending or the bus is free, and that the configured start address is not above the end address. The bench memory model is a registered lookup. Its grant is the request gated by a test switch, so the grant can be withheld to cover the starved case. Every range the bench programs lies inside the memory with start ≤ end. Bus traffic comes from an always-idle pattern, an always-busy pattern and a pseudo-random pattern that is busy three cycles in four.

// File: rtl/sig_scan_pkg.sv
`timescale 1ns/1ps
package sig_scan_pkg;
  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_END   = 2'd1,
    SEL_REF   = 2'd2,
    SEL_CTRL  = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2
  } scan_st_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_CLR_BIT = 1;
  localparam int CTRL_WIN_LSB = 2;
endpackage

// File: rtl/sig_scan_cfg.sv
`timescale 1ns/1ps
module sig_scan_cfg
  import sig_scan_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int WIN_W   = 8,
  parameter int CFG_W   = 32,
  parameter int WIN_RST = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [1:0]        sel,
  input  logic [CFG_W-1:0]  wdata,
  output logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] end_addr,
  output logic [DATA_W-1:0] ref_sig,
  output logic [WIN_W-1:0]  window,
  output logic              enable,
  output logic              clr_err
);
  cfg_sel_e sel_e;
  assign sel_e = cfg_sel_e'(sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_addr <= '0;
      end_addr   <= '1;
      ref_sig    <= '0;
      window     <= WIN_W'(WIN_RST);
      enable     <= 1'b0;
      clr_err    <= 1'b0;
    end else begin
      clr_err <= 1'b0;
      if (wr) begin
        case (sel_e)
          // range and reference are frozen while a scan is running
          SEL_START: if (!enable) start_addr <= wdata[ADDR_W-1:0];
          SEL_END:   if (!enable) end_addr   <= wdata[ADDR_W-1:0];
          SEL_REF:   if (!enable) ref_sig    <= wdata[DATA_W-1:0];
          SEL_CTRL: begin
            enable  <= wdata[CTRL_EN_BIT];
            clr_err <= wdata[CTRL_CLR_BIT];
            window  <= wdata[CTRL_WIN_LSB +: WIN_W];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sig_scan_misr.sv
`timescale 1ns/1ps
module sig_scan_misr #(
  parameter int          W    = 16,
  parameter int unsigned POLY = 32'h1021,
  parameter int unsigned SEED = 32'hFFFF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         seed,
  input  logic         fold,
  input  logic [W-1:0] din,
  output logic [W-1:0] sig_q,
  output logic [W-1:0] sig_nx
);
  localparam logic [W-1:0] POLY_V = POLY[W-1:0];
  localparam logic [W-1:0] SEED_V = SEED[W-1:0];

  logic [W-1:0] shifted;

  always_comb begin
    shifted = {sig_q[W-2:0], 1'b0};
    if (sig_q[W-1]) shifted = shifted ^ POLY_V;
    sig_nx = shifted ^ din;
  end

  always_ff @(posedge clk) begin
    if (rst)       sig_q <= SEED_V;
    else if (seed) sig_q <= SEED_V;
    else if (fold) sig_q <= sig_nx;
  end
endmodule

// File: rtl/sig_scan_seq.sv
`timescale 1ns/1ps
module sig_scan_seq
  import sig_scan_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WIN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] end_addr,
  input  logic [WIN_W-1:0]  window,
  input  logic              cpu_busy,
  input  logic              scan_gnt,
  output logic              rd_en,
  output logic [ADDR_W-1:0] addr,
  output logic              scan_req,
  output logic              rvalid,
  output logic              pass_done,
  output logic              seed
);
  scan_st_e          st;
  logic [WIN_W-1:0]  cnt;

  assign rd_en     = (st == ST_RUN) && (!cpu_busy || scan_gnt);
  assign scan_req  = (st == ST_RUN) && (cnt == '0);
  assign pass_done = (st == ST_TAIL);
  assign seed      = ((st == ST_IDLE) && enable) || (st == ST_TAIL);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      addr   <= '0;
      cnt    <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en && enable;
      if (!enable) begin
        st <= ST_IDLE;
      end else begin
        case (st)
          ST_IDLE: begin
            st   <= ST_RUN;
            addr <= start_addr;
            cnt  <= window;
          end
          ST_RUN: begin
            if (rd_en) begin
              cnt <= window;
              if (addr == end_addr) st <= ST_TAIL;
              else                  addr <= addr + 1'b1;
            end else if (cnt != '0) begin
              cnt <= cnt - 1'b1;
            end
          end
          ST_TAIL: begin
            st   <= ST_RUN;
            addr <= start_addr;
            cnt  <= window;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mem_sig_scanner.sv
`timescale 1ns/1ps
module mem_sig_scanner #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int WIN_W   = 8,
  parameter int CFG_W   = 32,
  parameter int CNT_W   = 16,
  parameter int WIN_RST = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              cpu_busy,
  output logic              scan_req,
  input  logic              scan_gnt,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              irq,
  output logic              err_flag,
  output logic [CNT_W-1:0]  pass_count,
  output logic [DATA_W-1:0] sig_out
);
  logic [ADDR_W-1:0] cfg_start, cfg_end;
  logic [DATA_W-1:0] cfg_ref;
  logic [WIN_W-1:0]  cfg_win;
  logic              cfg_en, cfg_clr;
  logic              rvalid, pass_done, seed;
  logic [DATA_W-1:0] sig_q, sig_nx;
  logic              mismatch;

  sig_scan_cfg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_W(WIN_W),
    .CFG_W(CFG_W), .WIN_RST(WIN_RST)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr(cfg_wr), .sel(cfg_sel), .wdata(cfg_wdata),
    .start_addr(cfg_start), .end_addr(cfg_end), .ref_sig(cfg_ref),
    .window(cfg_win), .enable(cfg_en), .clr_err(cfg_clr)
  );

  sig_scan_seq #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_seq (
    .clk(clk), .rst(rst), .enable(cfg_en),
    .start_addr(cfg_start), .end_addr(cfg_end), .window(cfg_win),
    .cpu_busy(cpu_busy), .scan_gnt(scan_gnt),
    .rd_en(mem_rd_en), .addr(mem_addr), .scan_req(scan_req),
    .rvalid(rvalid), .pass_done(pass_done), .seed(seed)
  );

  sig_scan_misr #(.W(DATA_W)) u_misr (
    .clk(clk), .rst(rst), .seed(seed), .fold(rvalid),
    .din(mem_rdata), .sig_q(sig_q), .sig_nx(sig_nx)
  );

  // in the tail cycle the last word is on mem_rdata; sig_nx is the final value
  assign mismatch = (sig_nx != cfg_ref);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq        <= 1'b0;
      err_flag   <= 1'b0;
      pass_count <= '0;
      sig_out    <= '0;
    end else begin
      irq <= pass_done && mismatch;
      if (pass_done) begin
        pass_count <= pass_count + 1'b1;
        sig_out    <= sig_nx;
      end
      if (pass_done && mismatch) err_flag <= 1'b1;
      else if (cfg_clr)          err_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/sig_scan_chk.sv
`timescale 1ns/1ps
module sig_scan_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_busy,
  input logic              scan_gnt,
  input logic              scan_req,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] cfg_start,
  input logic [ADDR_W-1:0] cfg_end,
  input logic              cfg_en,
  input logic              irq,
  input logic              err_flag,
  input logic [CNT_W-1:0]  pass_count
);
  // R1
  bus_free_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> (!cpu_busy || scan_gnt));

  // R2
  addr_window_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> ((mem_addr >= cfg_start) && (mem_addr <= cfg_end)));

  // R4
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R4
  irq_sets_err_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> err_flag);

  // R5
  steal_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (scan_req && scan_gnt) |-> mem_rd_en);

  // R6
  pass_step_chk: assert property (@(posedge clk) disable iff (rst)
    (pass_count != $past(pass_count)) |-> (pass_count == $past(pass_count) + 1'b1));

  // R7
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && $past(cfg_en)) |-> ($stable(cfg_start) && $stable(cfg_end)));

  // R8
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (!irq && !err_flag && (pass_count == '0)));
endmodule

bind mem_sig_scanner sig_scan_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cpu_busy(cpu_busy), .scan_gnt(scan_gnt),
  .scan_req(scan_req), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
  .cfg_start(cfg_start), .cfg_end(cfg_end), .cfg_en(cfg_en),
  .irq(irq), .err_flag(err_flag), .pass_count(pass_count)
);

// File: tb/mem_sig_scanner_tb.sv
`timescale 1ns/1ps
module mem_sig_scanner_tb;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int WW = 8;
  localparam int CW = 32;
  localparam int NW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_wr = 1'b0;
  logic [1:0]    cfg_sel = 2'd0;
  logic [CW-1:0] cfg_wdata = '0;
  logic          cpu_busy = 1'b0;
  logic          scan_req, scan_gnt, mem_rd_en, irq, err_flag;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata = '0;
  logic [NW-1:0] pass_count;
  logic [DW-1:0] sig_out;

  always #4 clk = ~clk;

  mem_sig_scanner #(.ADDR_W(AW), .DATA_W(DW), .WIN_W(WW), .CFG_W(CW), .CNT_W(NW)) u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cpu_busy(cpu_busy), .scan_req(scan_req), .scan_gnt(scan_gnt),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .irq(irq), .err_flag(err_flag), .pass_count(pass_count), .sig_out(sig_out)
  );

  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] memv(input int a);
    logic [31:0] p;
    p = a * 32'd40503;
    return p[15:0] ^ 16'h3C5A;
  endfunction

  function automatic logic [DW-1:0] step(input logic [DW-1:0] s, input logic [DW-1:0] d);
    logic [DW-1:0] y;
    y = {s[DW-2:0], 1'b0};
    if (s[DW-1]) y = y ^ 16'h1021;
    return y ^ d;
  endfunction

  function automatic logic [DW-1:0] exp_sig(input int s, input int e);
    logic [DW-1:0] x;
    x = 16'hFFFF;
    for (int a = s; a <= e; a++) x = step(x, memv(a));
    return x;
  endfunction

  // memory model: one-cycle read latency
  always_ff @(posedge clk) if (mem_rd_en) mem_rdata <= memv(int'(mem_addr));

  // arbiter model
  bit gnt_on = 1'b1;
  assign scan_gnt = scan_req & gnt_on;

  // processor traffic
  int busy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (busy_mode)
      0: cpu_busy = 1'b0;
      1: cpu_busy = 1'b1;
      default: cpu_busy = (lfsr[1:0] != 2'b00);
    endcase
  end

  // monitor
  int cyc = 0, last_fetch = 0, max_gap = 0, addr_bad = 0, r1_bad = 0;
  int irq_cnt = 0, req_cnt = 0, fetch_cnt = 0;
  bit have_last = 0, mon_on = 0;
  int mon_start = 0, mon_end = 0, exp_addr = 0;
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (irq) irq_cnt++;
      if (scan_req) req_cnt++;
      if (mem_rd_en) begin
        fetch_cnt++;
        if (cpu_busy && !scan_gnt) r1_bad++;
        if (mon_on) begin
          if (int'(mem_addr) != exp_addr) addr_bad++;
          exp_addr = (exp_addr == mon_end) ? mon_start : exp_addr + 1;
          if (have_last && (cyc - last_fetch) > max_gap) max_gap = cyc - last_fetch;
          last_fetch = cyc;
          have_last = 1;
        end
      end
    end
  end

  int base_pass = 0;

  task automatic cfg_write(input logic [1:0] sel, input logic [CW-1:0] d);
    @(posedge clk); #1;
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  function automatic logic [CW-1:0] ctrl(input bit en, input bit clr, input int win);
    return CW'(win) << 2 | CW'(clr) << 1 | CW'(en);
  endfunction

  task automatic reset_mon(input int s, input int e);
    mon_on = 1; mon_start = s; mon_end = e; exp_addr = s;
    max_gap = 0; have_last = 0; addr_bad = 0; r1_bad = 0;
    irq_cnt = 0; req_cnt = 0; fetch_cnt = 0;
    base_pass = int'(pass_count);
  endtask

  task automatic arm(input int s, input int e, input logic [DW-1:0] rf, input int win);
    cfg_write(2'd3, ctrl(0, 0, win));
    repeat (3) @(posedge clk);
    cfg_write(2'd0, CW'(s));
    cfg_write(2'd1, CW'(e));
    cfg_write(2'd2, CW'(rf));
    @(negedge clk);
    reset_mon(s, e);
    cfg_write(2'd3, ctrl(1, 0, win));
  endtask

  task automatic wait_pass(input int n);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (int'(pass_count) >= base_pass + n) break;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!irq && !err_flag && !scan_req && !mem_rd_en, "R8", "control outputs after reset",
          {irq, err_flag, scan_req, mem_rd_en}, 0);
    check(pass_count == 0 && sig_out == 0, "R8", "counter and signature after reset",
          pass_count, 0);
  endtask

  task automatic t_match();
    logic [DW-1:0] e;
    e = exp_sig(0, 15);
    busy_mode = 0; gnt_on = 1;
    arm(0, 15, e, 8);
    wait_pass(1);
    check(sig_out == e, "R3", "signature over 0..15", sig_out, e);
    check(addr_bad == 0, "R2", "ascending address order", addr_bad, 0);
    wait_pass(2);
    check(int'(pass_count) == base_pass + 2, "R6", "two passes, auto restart", pass_count, base_pass + 2);
    check(irq_cnt == 0 && !err_flag, "R4", "no irq on match", irq_cnt, 0);
    check(addr_bad == 0, "R2", "wrap to start address", addr_bad, 0);
  endtask

  task automatic t_mismatch();
    logic [DW-1:0] e;
    e = exp_sig(2, 9);
    busy_mode = 0;
    arm(2, 9, e ^ 16'h0001, 8);
    wait_pass(2);
    repeat (2) @(negedge clk);
    check(irq_cnt == 2, "R4", "one irq pulse per bad pass", irq_cnt, 2);
    check(err_flag == 1'b1, "R4", "sticky error set", err_flag, 1);
    check(sig_out == e, "R3", "signature over 2..9", sig_out, e);
  endtask

  task automatic t_clear();
    cfg_write(2'd3, ctrl(0, 1, 8));
    repeat (3) @(negedge clk);
    check(err_flag == 1'b0, "R10", "error cleared by control write", err_flag, 0);
  endtask

  task automatic t_steal();
    logic [DW-1:0] e;
    e = exp_sig(0, 15);
    busy_mode = 1; gnt_on = 1;
    arm(0, 15, e, 4);
    wait_pass(1);
    check(sig_out == e, "R5", "pass completes under full load", sig_out, e);
    check(max_gap == 5, "R5", "steal spacing W+1", max_gap, 5);
    check(req_cnt > 0, "R5", "steal requests seen", req_cnt, 1);
    check(r1_bad == 0, "R1", "no read without grant under load", r1_bad, 0);
    // withhold grant: bus busy forever, nothing may be read
    cfg_write(2'd3, ctrl(0, 0, 4));
    gnt_on = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    reset_mon(0, 15);
    cfg_write(2'd3, ctrl(1, 0, 4));
    repeat (60) @(negedge clk);
    check(fetch_cnt == 0, "R1", "no read while busy and ungranted", fetch_cnt, 0);
    check(int'(pass_count) == base_pass, "R1", "no pass while starved", pass_count, base_pass);
    gnt_on = 1;
  endtask

  task automatic t_random();
    logic [DW-1:0] e;
    e = exp_sig(5, 40);
    busy_mode = 2; gnt_on = 1;
    arm(5, 40, e, 8);
    wait_pass(2);
    check(sig_out == e, "R3", "signature 5..40 under mixed traffic", sig_out, e);
    check(irq_cnt == 0 && !err_flag, "R4", "no irq under mixed traffic", irq_cnt, 0);
    check(addr_bad == 0, "R2", "order under mixed traffic", addr_bad, 0);
    check(r1_bad == 0, "R1", "reads only in free or granted cycles", r1_bad, 0);
    check(max_gap <= 10, "R5", "gap bounded by W+2", max_gap, 10);
  endtask

  task automatic t_lock();
    logic [DW-1:0] e;
    e = exp_sig(0, 15);
    busy_mode = 0;
    arm(0, 15, e, 8);
    cfg_write(2'd0, CW'(7));
    cfg_write(2'd1, CW'(9));
    cfg_write(2'd2, CW'(0));
    wait_pass(2);
    check(sig_out == e, "R7", "range unchanged by locked writes", sig_out, e);
    check(!err_flag && irq_cnt == 0, "R7", "reference unchanged by locked write", err_flag, 0);
    check(addr_bad == 0, "R7", "addresses still cover 0..15", addr_bad, 0);
  endtask

  task automatic t_abort();
    logic [DW-1:0] e;
    e = exp_sig(3, 30);
    busy_mode = 2;
    arm(3, 30, e, 8);
    repeat (10) @(posedge clk);
    cfg_write(2'd3, ctrl(0, 0, 8));
    repeat (10) @(negedge clk);
    check(int'(pass_count) == base_pass, "R9", "aborted pass not counted", pass_count, base_pass);
    reset_mon(3, 30);
    cfg_write(2'd3, ctrl(1, 0, 8));
    wait_pass(1);
    check(sig_out == e, "R9", "fresh pass after re-enable", sig_out, e);
    check(addr_bad == 0 && !err_flag, "R9", "restart at start address", addr_bad, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_match();
    t_mismatch();
    t_clear();
    t_steal();
    t_random();
    t_lock();
    t_abort();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 190000, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule